// File: doc/BRIEF.md
# Arbitrated Serial EEPROM Bit-Bang Port

This block gives software direct, bit-level control of an external single-wire-data serial EEPROM. The EEPROM pins sit behind a memory port that one other requester also uses. Software sets a request bit in a byte-wide control register and waits for the ready bit. It then toggles chip select, clock and data out through register writes, and samples the EEPROM's data output through a read-only bit. The command protocol of the EEPROM is left entirely to software.

The ready bit has two jobs. When the port is first granted, ready goes high in the same cycle as the grant, with no added delay. While the port is held, every write that keeps the request bit set drops ready. Ready then comes back after a fixed number of clock cycles (`DELAY_CYC`, 80 cycles by default, which is 800 ns at 100 MHz). Software can therefore pace the serial clock by polling ready between writes.

The competing requester has a level request input and a grant output. Whichever side holds the port keeps it until its own request goes away. When the port is free and both sides ask in the same cycle, the other requester wins.

Top module: `seeprom_port`

## Requirements
- R1: After reset every register bit reads 0, the EEPROM pins are low and neither side holds the port.
- R2: A write that sets bit 5 (port request) while the port is free and the other request is low grants the EEPROM side at that same clock edge. Ready (bit 4) reads 1 right after that edge.
- R3: While the other requester holds the port, a pending EEPROM request waits with ready low. When both ask for a free port at the same edge, the other requester wins. The EEPROM grant follows at the edge where the other request is sampled low.
- R4: A grant is never preempted. While the EEPROM side holds the port, `oth_gnt` stays low and the other request shows as pending in bit 6. `oth_gnt` rises at the edge that releases the EEPROM grant.
- R5: While granted, `ee_cs`, `ee_ck` and `ee_do` follow register bits 3, 2 and 1. While not granted, all three are low whatever those bits hold.
- R6: Bit 0 reads the `ee_di` pin while granted and reads 0 otherwise.
- R7: A write made while granted that keeps bit 5 set clears ready at its edge. Ready returns to 1 exactly `DELAY_CYC` clock edges later.
- R8: A further such write during the countdown restarts the full delay.
- R9: A write that clears bit 5 releases the port at its own edge. Ready reads 0 and the pins fall, even in the middle of a countdown.
- R10: Bits 7 and 6 read the other side's grant and request, and bits 5 to 1 read back the stored values. Writes to bits 7, 6, 4 and 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| oth_req | input | 1 | Competing requester asks for the shared port |
| oth_gnt | output | 1 | Competing requester holds the shared port |
| ee_cs | output | 1 | EEPROM chip select |
| ee_ck | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Data to the EEPROM |
| ee_di | input | 1 | Data from the EEPROM |

## Verification
The bench checks that ready rises in the grant cycle itself. A design that ran the pacing delay on the first grant would leave software waiting for no reason. It counts the exact number of cycles ready stays low after a write, and checks that a second write restarts the delay. An off-by-one counter, or one that ignores a restart, would make software clock the EEPROM too fast. It also covers a request made while the other side holds the port, a request that ties with the other side on a free port, and a release in the middle of a countdown. Each of these shows a wrong arbiter at once: the EEPROM side would be granted early, the port would be preempted, or both grants would be high together. The bench also checks that the pins stay low while the register bits are set without a grant, and that writes to read-only bits are ignored.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  // Register bit positions; software decodes these.
  localparam int unsigned B_OACK = 7;  // other requester owns the port
  localparam int unsigned B_OREQ = 6;  // other requester asking
  localparam int unsigned B_REQ  = 5;  // EEPROM port request
  localparam int unsigned B_RDY  = 4;  // grant / pacing ready
  localparam int unsigned B_CS   = 3;
  localparam int unsigned B_CK   = 2;
  localparam int unsigned B_DO   = 1;
  localparam int unsigned B_DI   = 0;

  localparam int unsigned REG_W = 8;

  // Bits software may write.
  localparam logic [REG_W-1:0] WR_MASK = (REG_W'(1) << B_REQ) | (REG_W'(1) << B_CS) |
                                         (REG_W'(1) << B_CK)  | (REG_W'(1) << B_DO);

  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_OTHER = 2'd1,
    PORT_EE    = 2'd2
  } port_owner_e;

endpackage

// File: rtl/seeprom_ctlreg.sv
module seeprom_ctlreg
  import seeprom_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] ctl_d
);

  // Next-state: only writable positions take the written value.
  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d = wr_data & WR_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/seeprom_arb.sv
module seeprom_arb
  import seeprom_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ee_req_d,   // EEPROM request as of this edge
  input  logic        oth_req,
  output port_owner_e owner_q,
  output port_owner_e owner_d
);

  // Holder keeps the port until its own request drops; ties on a free
  // port go to the other requester.
  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      PORT_IDLE: begin
        if (oth_req) begin
          owner_d = PORT_OTHER;
        end else if (ee_req_d) begin
          owner_d = PORT_EE;
        end
      end
      PORT_OTHER: begin
        if (!oth_req) begin
          owner_d = ee_req_d ? PORT_EE : PORT_IDLE;
        end
      end
      PORT_EE: begin
        if (!ee_req_d) begin
          owner_d = oth_req ? PORT_OTHER : PORT_IDLE;
        end
      end
      default: owner_d = PORT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= PORT_IDLE;
    end else begin
      owner_q <= owner_d;
    end
  end

endmodule

// File: rtl/seeprom_pace.sv
module seeprom_pace #(
  parameter int unsigned DELAY_CYC = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt_d,        // EEPROM side owns the port after this edge
  input  logic grant_start,  // grant begins at this edge
  input  logic restart,      // paced write at this edge
  output logic rdy_q
);

  localparam int unsigned CNT_W = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC + 1);
  localparam logic [CNT_W-1:0] DLY  = CNT_W'(DELAY_CYC);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!gnt_d) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (grant_start) begin
      cnt_d = '0;
      rdy_d = 1'b1;
    end else if (restart) begin
      cnt_d = DLY;
      rdy_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - ONE;
      rdy_d = (cnt_q == ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

endmodule

// File: rtl/seeprom_port.sv
module seeprom_port
  import seeprom_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       oth_req,
  output logic       oth_gnt,
  output logic       ee_cs,
  output logic       ee_ck,
  output logic       ee_do,
  input  logic       ee_di
);

  logic [REG_W-1:0] ctl_q, ctl_d;
  port_owner_e      owner_q, owner_d;
  logic             ee_gnt, ee_gnt_d;
  logic             grant_start, restart;
  logic             rdy_q;
  logic [2:0]       pin_q, pin_d;

  seeprom_ctlreg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctl_q   (ctl_q),
    .ctl_d   (ctl_d)
  );

  seeprom_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ee_req_d (ctl_d[B_REQ]),
    .oth_req  (oth_req),
    .owner_q  (owner_q),
    .owner_d  (owner_d)
  );

  assign ee_gnt      = (owner_q == PORT_EE);
  assign ee_gnt_d    = (owner_d == PORT_EE);
  assign oth_gnt     = (owner_q == PORT_OTHER);
  assign grant_start = ee_gnt_d && !ee_gnt;
  assign restart     = wr_en && ee_gnt && wr_data[B_REQ];

  seeprom_pace #(.DELAY_CYC(DELAY_CYC)) u_pace (
    .clk         (clk),
    .rst_n       (rst_n),
    .gnt_d       (ee_gnt_d),
    .grant_start (grant_start),
    .restart     (restart),
    .rdy_q       (rdy_q)
  );

  // Pins are registered from the next-state values so they switch with the
  // grant and register, glitch-free and gated low without a grant.
  always_comb begin
    pin_d = '0;
    if (ee_gnt_d) begin
      pin_d = {ctl_d[B_CS], ctl_d[B_CK], ctl_d[B_DO]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
    end else begin
      pin_q <= pin_d;
    end
  end

  assign ee_cs = pin_q[2];
  assign ee_ck = pin_q[1];
  assign ee_do = pin_q[0];

  always_comb begin
    rd_data         = ctl_q & WR_MASK;
    rd_data[B_OACK] = oth_gnt;
    rd_data[B_OREQ] = oth_req;
    rd_data[B_RDY]  = rdy_q;
    rd_data[B_DI]   = ee_gnt && ee_di;
  end

endmodule

// File: rtl/seeprom_port_chk.sv
module seeprom_port_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wr_req,
  input logic gnt,
  input logic oth_gnt,
  input logic rdy,
  input logic ee_cs,
  input logic ee_ck,
  input logic ee_do
);

  // R2: the first grant is ready at once
  assert_ready_on_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt) |-> rdy);

  // R4: the two sides never both hold the port
  assert_grant_mutex_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt && oth_gnt));

  // R4: a held EEPROM grant persists until a write clears the request
  assert_no_preempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt) && !$past(wr_en && !wr_req)) |-> gnt);

  // R5: pins idle without a grant
  assert_pins_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt |-> (!ee_cs && !ee_ck && !ee_do));

  // R7: a paced write drops ready at its edge
  assert_write_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt) && $past(wr_en && wr_req)) |-> !rdy);

  // R9: clearing the request releases at once
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gnt && wr_en && !wr_req) |-> (!gnt && !rdy));

endmodule

bind seeprom_port seeprom_port_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_req  (wr_data[5]),
  .gnt     (ee_gnt),
  .oth_gnt (oth_gnt),
  .rdy     (rd_data[4]),
  .ee_cs   (ee_cs),
  .ee_ck   (ee_ck),
  .ee_do   (ee_do)
);

// File: tb/seeprom_port_bench.sv
module seeprom_port_bench;

  localparam int unsigned DLY = 80;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       oth_req;
  logic       oth_gnt;
  logic       ee_cs, ee_ck, ee_do, ee_di;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 0;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic [3:0] pins;  // {oth_gnt, cs, ck, do}
  } exp_t;

  exp_t sb_q[$];

  seeprom_port #(.DELAY_CYC(DLY)) u_seeprom_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .oth_req (oth_req),
    .oth_gnt (oth_gnt),
    .ee_cs   (ee_cs),
    .ee_ck   (ee_ck),
    .ee_do   (ee_do),
    .ee_di   (ee_di)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Monitor: pops expected items and compares against the outputs.
  initial begin
    forever begin
      exp_t it;
      wait (sb_q.size() > 0);
      #1;
      it = sb_q.pop_front();
      n_vec++;
      if (rd_data !== it.rd) begin
        n_miss++;
        $display("FAIL %s rd_data actual=%h expected=%h", it.tag, rd_data, it.rd);
      end
      n_vec++;
      if ({oth_gnt, ee_cs, ee_ck, ee_do} !== it.pins) begin
        n_miss++;
        $display("FAIL %s pins actual=%b expected=%b", it.tag,
                 {oth_gnt, ee_cs, ee_ck, ee_do}, it.pins);
      end
    end
  end

  task automatic expect_st(string tag, logic [7:0] rd, logic [3:0] pins);
    sb_q.push_back('{tag, rd, pins});
    wait (sb_q.size() == 0);
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_ready(string tag, int exp);
    int n = 0;
    while (!rd_data[4] && n < 4 * DLY) begin
      @(negedge clk);
      n++;
    end
    n_vec++;
    if (n != exp) begin
      n_miss++;
      $display("FAIL %s ready delay actual=%0d expected=%0d", tag, n, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_miss++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = 8'h00;
    oth_req = 1'b0;
    ee_di   = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    expect_st("R1 reset", 8'h00, 4'b0000);

    // R5/R10: pin bits set without a request stay off the pins
    wr(8'h0E);
    expect_st("R5 ungranted pins", 8'h0E, 4'b0000);
    // R10: read-only positions ignore writes
    wr(8'hD1);
    expect_st("R10 ro bits ignored", 8'h00, 4'b0000);

    // R2: grant with immediate ready
    wr(8'h2A);
    expect_st("R2 grant ready", 8'h3A, 4'b0101);

    // R6: data-in reflected while granted
    ee_di = 1'b1;
    expect_st("R6 di granted", 8'h3B, 4'b0101);

    // R7: paced write
    wr(8'h2E);
    expect_st("R7 ready dropped", 8'h2F, 4'b0111);
    count_ready("R7 delay", DLY);
    expect_st("R7 ready back", 8'h3F, 4'b0111);

    // R8: restart during countdown
    wr(8'h2A);
    idle(30);
    expect_st("R8 mid count", 8'h2B, 4'b0101);
    wr(8'h2A);
    count_ready("R8 restarted delay", DLY);

    // R4: other request waits while EEPROM holds the port
    oth_req = 1'b1;
    idle(3);
    expect_st("R4 no preempt", 8'h7B, 4'b0101);

    // R9/R4: release hands the port over at the same edge
    wr(8'h00);
    expect_st("R9 release handover", 8'hC0, 4'b1000);

    // R3: request while other holds the port waits
    wr(8'h28);
    expect_st("R3 waiting", 8'hE8, 4'b1000);
    idle(5);
    expect_st("R3 still waiting", 8'hE8, 4'b1000);
    oth_req = 1'b0;
    idle(1);
    expect_st("R3 granted after other", 8'h39, 4'b0100);

    // R9: release mid-countdown, then a fresh grant is ready at once
    wr(8'h2C);
    expect_st("R9 count start", 8'h2D, 4'b0110);
    idle(10);
    wr(8'h0C);
    expect_st("R9 release mid count", 8'h0C, 4'b0000);
    wr(8'h2C);
    expect_st("R2 regrant ready", 8'h3D, 4'b0110);

    // R3: tie on a free port goes to the other requester
    wr(8'h00);
    expect_st("R9 idle", 8'h00, 4'b0000);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = 8'h20;
    oth_req = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    expect_st("R3 tie other wins", 8'hE0, 4'b1000);
    oth_req = 1'b0;
    idle(1);
    expect_st("R3 tie then ee", 8'h31, 4'b0000);

    summary();
  end

endmodule